// File: doc/BRIEF.md
# Decompressor Mode Control Sequencer

This block supervises a record-oriented decompression engine that takes bytes from an input FIFO and hands them to an output FIFO. It holds four control bits: engine enable, pass-through select, stop at end of record and stop at end of transfer. From these it decides, cycle by cycle, whether to pop the input FIFO. The bytes it pops flow through a fixed-depth placeholder pipeline that stands in for the real decoder. Each byte carries an end-of-record flag and an end-of-transfer flag. Each byte is also tagged with the mode, decode or pass-through, that was in force when it was popped.

Software programs the controls through a single-cycle register write and reads them back on `ctrlState`. The block keeps an empty flag from the pipeline occupancy. The pass-through select may change only while the engine is stopped and that flag is set. An accepted change of the select raises a one-cycle dictionary-clear pulse. Turning the engine on or off never raises it. When a stop bit is set, the engine clears its own enable as the marked byte leaves the pipeline. Bytes of the following record that were already popped stay inside the pipeline until the engine is enabled again.

Top module: `dcmp_mode_seq`

## Requirements
- R1: `inPop` is high only in a cycle where the enable bit (ctrlState bit 0) is 1, `inValid` is 1 and `outFull` is 0. The popped byte is taken in that same cycle.
- R2: A byte popped in cycle t appears on the output with `outValid` high in cycle t+STAGES, when no stall occurs. Bytes leave in pop order, with their `outEor`/`outEot` flags unchanged.
- R3: Register write data bit 1 (pass-through) is stored only when the enable bit is 0 and `engEmpty` is 1 before the write. Otherwise ctrlState bit 1 keeps its value. Bits 0 (enable), 2 (stop at record) and 3 (stop at transfer) are always stored.
- R4: `dictClr` is high for exactly the one cycle after an accepted write that changes the pass-through bit. Enable changes and writes of an unchanged pass-through value leave it low.
- R5: With bit 2 set, the cycle in which a byte flagged end-of-record leaves the pipeline issues no pop. From the next cycle the enable bit is 0 and no further pops occur.
- R6: With bit 3 set and bit 2 clear, end-of-record bytes do not stop the engine. A byte flagged end-of-transfer clears the enable bit in the same way as R5.
- R7: Bytes popped before a stop takes effect remain in the pipeline with `engEmpty` low. Setting the enable bit again delivers them in order.
- R8: `engEmpty` is 1 exactly when the pipeline holds no byte and no pop is being issued.
- R9: While `outFull` is 1, no pop is issued, `outValid` stays 0 and the pipeline contents are kept.
- R10: Synchronous reset (`rst` high) clears all control bits, so decode mode is selected. It sets `engEmpty` to 1 and holds `dictClr` at 1 until the first clock edge after reset is released.
- R11: `outPass` carries the pass-through bit that was in force when the byte was popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Control register write strobe |
| regWrData | input | 4 | Write data: bit0 enable, bit1 pass-through, bit2 stop at record, bit3 stop at transfer |
| ctrlState | output | 4 | Current control bits, same layout as the write data |
| inValid | input | 1 | Input FIFO holds a byte |
| inByte | input | DATA_W | Byte at the head of the input FIFO |
| inEor | input | 1 | Head byte ends a record |
| inEot | input | 1 | Head byte ends a transfer |
| inPop | output | 1 | Pop the input FIFO head this cycle |
| outFull | input | 1 | Output FIFO cannot accept a byte |
| outValid | output | 1 | Output byte is written this cycle |
| outByte | output | DATA_W | Output byte |
| outEor | output | 1 | Output byte ends a record |
| outEot | output | 1 | Output byte ends a transfer |
| outPass | output | 1 | Mode tag of the output byte (1 = pass-through) |
| engEmpty | output | 1 | Engine holds no data |
| dictClr | output | 1 | Dictionary clear pulse |

## Verification
The hardest state to reach from the ports is a stopped engine that still holds bytes of the next record. The flag `engEmpty` is low in that state, and a pass-through write must be refused there. The stimulus reaches it by loading two back-to-back records into the modelled input FIFO with stop-at-record set. The engine keeps popping while the end-of-record byte crosses the pipeline, so STAGES-1 bytes of the second record are left inside. The bench then tries a pass-through write and re-enables the engine to recover those bytes. A similar sequence with a trailing third record covers the stop at end of transfer.

// File: rtl/dcmp_mode_pkg.sv
`timescale 1ns/1ps
package dcmp_mode_pkg;

  localparam int CTRL_W     = 4;
  localparam int BIT_EN     = 0;
  localparam int BIT_PASS   = 1;
  localparam int BIT_HREC   = 2;
  localparam int BIT_HXFER  = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic run;      // pipeline advances this cycle
    logic pop;      // a new byte enters stage 0
    logic passSel;  // mode tag attached to the new byte
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic exitValid;
    logic exitEor;
    logic exitEot;
    logic occZero;
  } dpStatus_t;

endpackage

// File: rtl/dcmp_mode_dpath.sv
`timescale 1ns/1ps
module dcmp_mode_dpath
  import dcmp_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inEor,
  input  logic              inEot,
  output dpStatus_t         dpStat,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              outEor,
  output logic              outEot,
  output logic              outPass
);

  localparam int OCC_W = $clog2(STAGES + 2);
  localparam int LAST  = STAGES - 1;

  typedef struct packed {
    logic              vld;
    logic              eor;
    logic              eot;
    logic              tag;
    logic [DATA_W-1:0] dat;
  } stage_t;

  stage_t     stg [STAGES];
  logic [OCC_W-1:0] occCnt;
  logic       exitNow;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[0] <= '0;
        end else if (strobe.run) begin
          stg[0].vld <= strobe.pop;
          stg[0].eor <= inEor;
          stg[0].eot <= inEot;
          stg[0].tag <= strobe.passSel;
          stg[0].dat <= inByte;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[g] <= '0;
        end else if (strobe.run) begin
          stg[g] <= stg[g-1];
        end
      end
    end
  end

  assign exitNow = strobe.run && stg[LAST].vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      occCnt <= '0;
    end else begin
      occCnt <= occCnt + OCC_W'(strobe.pop) - OCC_W'(exitNow);
    end
  end

  always_comb begin
    dpStat.exitValid = stg[LAST].vld;
    dpStat.exitEor   = stg[LAST].eor;
    dpStat.exitEot   = stg[LAST].eot;
    dpStat.occZero   = (occCnt == '0);
    outValid         = exitNow;
    outByte          = stg[LAST].dat;
    outEor           = stg[LAST].eor;
    outEot           = stg[LAST].eot;
    outPass          = stg[LAST].tag;
  end

endmodule

// File: rtl/dcmp_mode_ctrl.sv
`timescale 1ns/1ps
module dcmp_mode_ctrl
  import dcmp_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              inValid,
  input  logic              outFull,
  input  dpStatus_t         dpStat,
  output ctrlStrobe_t       strobe,
  output logic              inPop,
  output logic [CTRL_W-1:0] ctrlState,
  output logic              engEmpty,
  output logic              dictClr
);

  logic enR, passR, hRecR, hXferR;
  logic run, haltNow, popNow, passWrOk, passChange;

  always_comb begin
    run        = enR && !outFull;
    haltNow    = run && dpStat.exitValid &&
                 ((dpStat.exitEor && hRecR) || (dpStat.exitEot && hXferR));
    popNow     = run && inValid && !haltNow;
    engEmpty   = dpStat.occZero && !popNow;
    passWrOk   = regWr && !enR && engEmpty;
    passChange = passWrOk && (regWrData[BIT_PASS] != passR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enR     <= 1'b0;
      passR   <= 1'b0;
      hRecR   <= 1'b0;
      hXferR  <= 1'b0;
      dictClr <= 1'b1;
    end else begin
      if (regWr) begin
        enR    <= regWrData[BIT_EN];
        hRecR  <= regWrData[BIT_HREC];
        hXferR <= regWrData[BIT_HXFER];
      end else if (haltNow) begin
        enR    <= 1'b0;
      end
      if (passWrOk) passR <= regWrData[BIT_PASS];
      dictClr <= passChange;
    end
  end

  always_comb begin
    strobe.run     = run;
    strobe.pop     = popNow;
    strobe.passSel = passR;
    inPop          = popNow;
    ctrlState      = '0;
    ctrlState[BIT_EN]    = enR;
    ctrlState[BIT_PASS]  = passR;
    ctrlState[BIT_HREC]  = hRecR;
    ctrlState[BIT_HXFER] = hXferR;
  end

endmodule

// File: rtl/dcmp_mode_seq.sv
`timescale 1ns/1ps
module dcmp_mode_seq
  import dcmp_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [3:0]        regWrData,
  output logic [3:0]        ctrlState,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inEor,
  input  logic              inEot,
  output logic              inPop,
  input  logic              outFull,
  output logic              outValid,
  output logic [DATA_W-1:0] outByte,
  output logic              outEor,
  output logic              outEot,
  output logic              outPass,
  output logic              engEmpty,
  output logic              dictClr
);

  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;

  dcmp_mode_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regWr     (regWr),
    .regWrData (regWrData),
    .inValid   (inValid),
    .outFull   (outFull),
    .dpStat    (dpStat),
    .strobe    (strobe),
    .inPop     (inPop),
    .ctrlState (ctrlState),
    .engEmpty  (engEmpty),
    .dictClr   (dictClr)
  );

  dcmp_mode_dpath #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inByte   (inByte),
    .inEor    (inEor),
    .inEot    (inEot),
    .dpStat   (dpStat),
    .outValid (outValid),
    .outByte  (outByte),
    .outEor   (outEor),
    .outEot   (outEot),
    .outPass  (outPass)
  );

endmodule

// File: rtl/dcmp_mode_seq_chk.sv
`timescale 1ns/1ps
module dcmp_mode_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       regWr,
  input logic [3:0] regWrData,
  input logic [3:0] ctrlState,
  input logic       inValid,
  input logic       inPop,
  input logic       outFull,
  input logic       outValid,
  input logic       outEor,
  input logic       outEot,
  input logic       engEmpty,
  input logic       dictClr
);

  a_r1_pop_gate: assert property (@(posedge clk) disable iff (rst)
    inPop |-> (ctrlState[0] && inValid && !outFull));

  a_r3_pass_locked: assert property (@(posedge clk) disable iff (rst)
    (regWr && !(!ctrlState[0] && engEmpty)) |=> $stable(ctrlState[1]));

  a_r4_clr_on_change: assert property (@(posedge clk) disable iff (rst)
    (regWr && !ctrlState[0] && engEmpty && (regWrData[1] != ctrlState[1])) |=> dictClr);

  a_r4_clr_needs_write: assert property (@(posedge clk) disable iff (rst)
    !regWr |=> !dictClr);

  a_r5_stop_record: assert property (@(posedge clk) disable iff (rst)
    (outValid && outEor && ctrlState[2] && !regWr) |=> !ctrlState[0]);

  a_r5_no_pop_on_stop: assert property (@(posedge clk) disable iff (rst)
    (outValid && outEor && ctrlState[2]) |-> !inPop);

  a_r6_stop_transfer: assert property (@(posedge clk) disable iff (rst)
    (outValid && outEot && ctrlState[3] && !regWr) |=> !ctrlState[0]);

  a_r8_empty_no_pop: assert property (@(posedge clk) disable iff (rst)
    engEmpty |-> !inPop);

  a_r9_full_no_out: assert property (@(posedge clk) disable iff (rst)
    outFull |-> !outValid);

endmodule

bind dcmp_mode_seq dcmp_mode_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .regWr     (regWr),
  .regWrData (regWrData),
  .ctrlState (ctrlState),
  .inValid   (inValid),
  .inPop     (inPop),
  .outFull   (outFull),
  .outValid  (outValid),
  .outEor    (outEor),
  .outEot    (outEot),
  .engEmpty  (engEmpty),
  .dictClr   (dictClr)
);

// File: tb/dcmp_mode_seq_bench.sv
`timescale 1ns/1ps
module dcmp_mode_seq_bench;

  localparam int DATA_W = 8;
  localparam int STAGES = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWr = 1'b0;
  logic [3:0] regWrData = '0;
  logic [3:0] ctrlState;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inByte = '0;
  logic inEor = 1'b0, inEot = 1'b0;
  logic inPop;
  logic outFull = 1'b0;
  logic outValid;
  logic [DATA_W-1:0] outByte;
  logic outEor, outEot, outPass;
  logic engEmpty, dictClr;

  always #4 clk = ~clk;

  dcmp_mode_seq #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dcmp_mode_seq (
    .clk(clk), .rst(rst), .regWr(regWr), .regWrData(regWrData),
    .ctrlState(ctrlState), .inValid(inValid), .inByte(inByte),
    .inEor(inEor), .inEot(inEot), .inPop(inPop), .outFull(outFull),
    .outValid(outValid), .outByte(outByte), .outEor(outEor),
    .outEot(outEot), .outPass(outPass), .engEmpty(engEmpty),
    .dictClr(dictClr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [9:0] inQ[$];
  logic [9:0] expQ[$];
  logic [9:0] outQ[$];
  int popCnt = 0;
  int cyc = 0;
  int firstPop = -1;
  int firstOut = -1;
  bit lastPop, lastOut, lastPass;
  bit fullReq = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit wr = 0, input logic [3:0] d = '0);
    bit popped;
    @(negedge clk);
    regWr     = wr;
    regWrData = d;
    outFull   = fullReq;
    inValid   = (inQ.size() > 0);
    if (inValid) {inEot, inEor, inByte} = inQ[0];
    else {inEot, inEor, inByte} = '0;
    #1;
    popped  = inPop;
    lastPop = inPop;
    lastOut = outValid;
    if (inPop && firstPop < 0) firstPop = cyc;
    if (outValid) begin
      outQ.push_back({outEot, outEor, outByte});
      lastPass = outPass;
      if (firstOut < 0) firstOut = cyc;
    end
    @(posedge clk);
    cyc++;
    if (popped) begin
      void'(inQ.pop_front());
      popCnt++;
    end
    #2;
    regWr = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(input logic [7:0] b, input bit eor, input bit eot);
    inQ.push_back({eot, eor, b});
    expQ.push_back({eot, eor, b});
  endtask

  task automatic compareOut(input string req);
    check(outQ.size() == expQ.size(), req, "output count", outQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < outQ.size(); i++)
      check(outQ[i] == expQ[i], req, "output byte/flags", outQ[i], expQ[i]);
  endtask

  task automatic clearLogs();
    outQ.delete();
    expQ.delete();
    firstPop = -1;
    firstOut = -1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    steps(3);
    check(ctrlState == 4'b0000, "R10", "ctrlState in reset", ctrlState, 0);
    check(engEmpty == 1'b1, "R10", "engEmpty in reset", engEmpty, 1);
    check(dictClr == 1'b1, "R10", "dictClr in reset", dictClr, 1);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check(dictClr == 1'b0, "R10", "dictClr after release", dictClr, 0);
    check(inPop == 1'b0, "R1", "no pop while disabled", inPop, 0);
  endtask

  task automatic t_basic();
    clearLogs();
    step(1, 4'b0001);
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i), i == 4, 1'b0);
    step();
    check(lastPop == 1'b1, "R1", "pop when enabled and data present", lastPop, 1);
    step();
    check(engEmpty == 1'b0, "R8", "engEmpty while bytes inside", engEmpty, 0);
    steps(14);
    compareOut("R2");
    check(firstOut - firstPop == STAGES, "R2", "pop-to-output latency",
          firstOut - firstPop, STAGES);
    check(ctrlState[0] == 1'b1, "R5", "no stop when stop bits clear", ctrlState[0], 1);
    check(engEmpty == 1'b1, "R8", "engEmpty after drain", engEmpty, 1);
  endtask

  task automatic t_stall();
    int popsBefore;
    int outsBefore;
    clearLogs();
    for (int i = 0; i < 6; i++) push(8'h20 + 8'(i), i == 5, 1'b0);
    steps(2);
    fullReq = 1;
    step();
    popsBefore = popCnt;
    outsBefore = outQ.size();
    for (int i = 0; i < 5; i++) begin
      step();
      check(!lastPop && !lastOut, "R9", "pop/out during full", {lastPop, lastOut}, 0);
    end
    check(popCnt == popsBefore, "R9", "pop count frozen", popCnt, popsBefore);
    check(outQ.size() == outsBefore, "R9", "out count frozen", outQ.size(), outsBefore);
    check(engEmpty == 1'b0, "R9", "contents kept while full", engEmpty, 0);
    fullReq = 0;
    steps(16);
    compareOut("R9");
  endtask

  task automatic t_pass();
    clearLogs();
    step(1, 4'b0011);
    check(ctrlState[1] == 1'b0, "R3", "pass write ignored while enabled", ctrlState[1], 0);
    check(dictClr == 1'b0, "R4", "no clear for refused write", dictClr, 0);
    step(1, 4'b0000);
    check(dictClr == 1'b0, "R4", "no clear on disable", dictClr, 0);
    step(1, 4'b0010);
    check(ctrlState[1] == 1'b1, "R3", "pass accepted when stopped and empty", ctrlState[1], 1);
    check(dictClr == 1'b1, "R4", "clear after pass change", dictClr, 1);
    step();
    check(dictClr == 1'b0, "R4", "clear lasts one cycle", dictClr, 0);
    step(1, 4'b0010);
    check(dictClr == 1'b0, "R4", "same pass value, no clear", dictClr, 0);
    step(1, 4'b0011);
    check(dictClr == 1'b0 && ctrlState[1], "R4", "enable keeps dictionary",
          {dictClr, ctrlState[1]}, 1);
    push(8'h33, 1'b1, 1'b0);
    steps(6);
    compareOut("R11");
    check(lastPass == 1'b1, "R11", "byte tagged pass-through", lastPass, 1);
    step(1, 4'b0010);
    step(1, 4'b0000);
    check(ctrlState[1] == 1'b0 && dictClr == 1'b1, "R4", "back to decode clears",
          {ctrlState[1], dictClr}, 1);
    step();
  endtask

  task automatic t_stopRecord();
    int pc;
    clearLogs();
    step(1, 4'b0101);
    for (int i = 0; i < 3; i++) push(8'h40 + 8'(i), i == 2, 1'b0);
    steps(10);
    check(ctrlState[0] == 1'b0, "R5", "enable cleared after record", ctrlState[0], 0);
    check(engEmpty == 1'b1, "R8", "empty after lone record", engEmpty, 1);
    compareOut("R5");
    pc = popCnt;
    push(8'h48, 1'b0, 1'b0);
    push(8'h49, 1'b1, 1'b0);
    steps(5);
    check(popCnt == pc, "R5", "no pops after stop", popCnt - pc, 0);
    check(inQ.size() == 2, "R5", "input FIFO untouched", inQ.size(), 2);
    step(1, 4'b0001);
    steps(8);
    compareOut("R7");
    check(engEmpty == 1'b1, "R7", "restart drains", engEmpty, 1);
  endtask

  task automatic t_carry();
    clearLogs();
    step(1, 4'b0101);
    for (int i = 0; i < 3; i++) push(8'h60 + 8'(i), i == 2, 1'b0);
    for (int i = 0; i < 3; i++) push(8'h70 + 8'(i), i == 2, 1'b0);
    steps(12);
    check(ctrlState[0] == 1'b0, "R5", "stopped at first record", ctrlState[0], 0);
    check(outQ.size() == 3, "R7", "only first record out", outQ.size(), 3);
    check(inQ.size() == 3 - (STAGES - 1), "R7", "bytes of next record popped",
          inQ.size(), 3 - (STAGES - 1));
    check(engEmpty == 1'b0, "R7", "empty low with carried bytes", engEmpty, 0);
    step(1, 4'b0110);
    check(ctrlState[1] == 1'b0, "R3", "pass refused while not empty", ctrlState[1], 0);
    check(dictClr == 1'b0, "R4", "no clear on refused pass", dictClr, 0);
    check(ctrlState[2] == 1'b1, "R3", "stop bit still stored", ctrlState[2], 1);
    step(1, 4'b0001);
    steps(10);
    compareOut("R7");
    check(engEmpty == 1'b1, "R7", "drained after restart", engEmpty, 1);
  endtask

  task automatic t_stopTransfer();
    clearLogs();
    step(1, 4'b1001);
    push(8'h50, 1'b0, 1'b0);
    push(8'h51, 1'b1, 1'b0);
    push(8'h52, 1'b0, 1'b0);
    push(8'h53, 1'b1, 1'b1);
    push(8'h54, 1'b0, 1'b0);
    push(8'h55, 1'b1, 1'b0);
    steps(14);
    check(ctrlState[0] == 1'b0, "R6", "stopped at end of transfer", ctrlState[0], 0);
    check(outQ.size() == 4, "R6", "record end did not stop", outQ.size(), 4);
    check(inQ.size() == 0 && engEmpty == 1'b0, "R7", "trailing bytes held",
          {inQ.size() == 0, engEmpty}, 2);
    step(1, 4'b0001);
    steps(8);
    compareOut("R6");
    check(engEmpty == 1'b1, "R8", "empty at end", engEmpty, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_pass();
    t_stopRecord();
    t_carry();
    t_stopTransfer();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule